// File: doc/BRIEF.md
# Queued Core-to-Bank Request Crossbar

This block links eight processor cores to a shared cache that is split into four independent banks. Every core presents one request at a time (address plus payload) on a valid/ready handshake. The crossbar works out the target bank from the cache-line address, so consecutive 64-byte lines fall in consecutive banks. It arbitrates among the cores that want the same bank and writes the winner into that bank's request queue. The entry is tagged with the number of the core that issued it, so the response path can route the answer back.

Each bank has its own small queue and its own arbiter, so requests to different banks never block each other. In one cycle, up to four cores can each hand a request to a different bank. Requests are never dropped. A core whose bank queue is full simply sees ready held low until space opens, and it keeps its request on its port until then. Each bank drains its queue through its own valid/ready output port at one entry per cycle.

Top module: `core_bank_xbar`

## Requirements
- R1: While reset is asserted (rst_n low, sampled on the clock), every queue empties, every round-robin pointer returns to core 0 and `bank_valid` is all zero from the following cycle.
- R2: A request goes to bank number `addr[7:6]` (64-byte lines, four banks); no other address bit affects the choice.
- R3: Every queued entry carries its address and payload unchanged, together with the 3-bit number of the issuing core, presented on `bank_src`.
- R4: Each bank queue holds 4 entries. While a bank queue is full, `req_ready` stays low for every core targeting that bank, including in a cycle where the bank pops. `req_ready` is never high without `req_valid`.
- R5: When several cores target one bank, the grant goes to the first requesting core at or after that bank's pointer, counting upward and wrapping from 7 to 0. After a grant, the pointer moves to the core just past the winner; without a grant it stays put.
- R6: Requests that one core sends to one bank leave the bank port in issue order, and a bank port delivers its entries in acceptance order.
- R7: Four cores that target four different banks are all accepted in the same cycle.
- R8: A bank accepts at most one request per cycle.
- R9: While `bank_valid` is high and `bank_ready` is low, the bank port holds its valid flag, address, payload and source number stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 8 | Per-core request valid |
| req_addr | input | 8*32 | Per-core byte address, core c at bits [c*32 +: 32] |
| req_data | input | 8*32 | Per-core payload, core c at bits [c*32 +: 32] |
| req_ready | output | 8 | Per-core acceptance this cycle |
| bank_valid | output | 4 | Bank queue head is present |
| bank_addr | output | 4*32 | Head address per bank |
| bank_data | output | 4*32 | Head payload per bank |
| bank_src | output | 4*3 | Issuing core number of the head entry per bank |
| bank_ready | input | 4 | Bank takes its head entry this cycle |

## Verification
A queue occupancy that drifts from the true count shows at the ports within one cycle. Either `bank_valid` goes high on an empty bank, or a core is accepted into a queue that already holds four entries. The checker counts pushes and pops at the ports and flags both cases. A round-robin pointer left in the wrong place shows up on the first contended cycle, as a `req_ready` on the wrong core. A corrupted queue slot appears as soon as that entry reaches the head, as a wrong address, payload or source number.

// File: rtl/xbar_pkg.sv
// Package: shared default sizes of the core-to-bank request crossbar.
// Assumes: the top module uses these only as parameter defaults.
package xbar_pkg;
    parameter int XB_CORES      = 8;
    parameter int XB_BANKS      = 4;
    parameter int XB_ADDR_W     = 32;
    parameter int XB_DATA_W     = 32;
    parameter int XB_LINE_BYTES = 64;
    parameter int XB_QDEPTH     = 4;
endpackage

// File: rtl/xbar_rr_arb.sv
// Module: round-robin arbiter for one bank.
// Picks the first requester at or after the pointer, wrapping upward.
// The pointer moves just past the winner, and only when a grant is issued.
// Assumes: N >= 2; en low suppresses the grant and freezes the pointer.
module xbar_rr_arb #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          en,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr;
    logic [IW-1:0] k;
    logic          found;

    // Scan the requesters starting at the pointer and pick the first one.
    always_comb begin
        gnt     = '0;
        gnt_idx = ptr;
        found   = 1'b0;
        k       = '0;
        for (int i = 0; i < N; i++) begin
            k = IW'((int'(ptr) + i) % N);
            if (!found && req[k]) begin
                found   = 1'b1;
                gnt_idx = k;
            end
        end
        if (en && found) gnt[gnt_idx] = 1'b1;
    end

    // Move the pointer past the core that was just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (en && found)
            ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
endmodule

// File: rtl/xbar_req_fifo.sv
// Module: circular request queue for one bank.
// Assumes: the caller never pushes while full; a pop while empty is ignored.
module xbar_req_fifo #(
    parameter int W     = 67,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] head,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    // Qualify the push and pop strobes and expose the head entry.
    always_comb begin
        full    = (cnt == CW'(DEPTH));
        valid   = (cnt != '0);
        do_push = push && !full;
        do_pop  = pop && valid;
        head    = mem[rp];
    end

    // Write the incoming entry into its slot.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    // Advance the read and write pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/core_bank_xbar.sv
// Module: queued crossbar from NUM_CORES request ports to NUM_BANKS cache banks.
// The bank is chosen from the address bits just above the line offset.
// Each bank has its own round-robin arbiter and request queue.
// Assumes: NUM_BANKS and LINE_BYTES are powers of two and NUM_BANKS >= 2.
module core_bank_xbar
    import xbar_pkg::*;
#(
    parameter int NUM_CORES  = XB_CORES,
    parameter int NUM_BANKS  = XB_BANKS,
    parameter int ADDR_W     = XB_ADDR_W,
    parameter int DATA_W     = XB_DATA_W,
    parameter int LINE_BYTES = XB_LINE_BYTES,
    parameter int QDEPTH     = XB_QDEPTH
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_CORES-1:0]                   req_valid,
    input  logic [NUM_CORES*ADDR_W-1:0]            req_addr,
    input  logic [NUM_CORES*DATA_W-1:0]            req_data,
    output logic [NUM_CORES-1:0]                   req_ready,
    output logic [NUM_BANKS-1:0]                   bank_valid,
    output logic [NUM_BANKS*ADDR_W-1:0]            bank_addr,
    output logic [NUM_BANKS*DATA_W-1:0]            bank_data,
    output logic [NUM_BANKS*$clog2(NUM_CORES)-1:0] bank_src,
    input  logic [NUM_BANKS-1:0]                   bank_ready
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int BSEL_W = $clog2(NUM_BANKS);
    localparam int SRC_W  = $clog2(NUM_CORES);
    localparam int ENT_W  = SRC_W + ADDR_W + DATA_W;

    logic [BSEL_W-1:0]                    tgt [NUM_CORES];
    logic [NUM_BANKS-1:0][NUM_CORES-1:0]  hit;
    logic [NUM_BANKS-1:0][NUM_CORES-1:0]  gnt;

    // Decode each core's target bank from its line address.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign tgt[c] = req_addr[c*ADDR_W + OFS_W +: BSEL_W];
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
            assign hit[b][c] = req_valid[c] && (tgt[c] == BSEL_W'(b));
        end
    end

    // A core is ready when any bank arbiter grants it.
    always_comb begin
        req_ready = '0;
        for (int b = 0; b < NUM_BANKS; b++) req_ready = req_ready | gnt[b];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             full, room, push;
        logic [SRC_W-1:0] widx;
        logic [ENT_W-1:0] push_ent, head;

        // The arbiter may grant only while the queue has room.
        always_comb begin
            room     = !full;
            push     = |gnt[b];
            push_ent = {widx, req_addr[widx*ADDR_W +: ADDR_W],
                        req_data[widx*DATA_W +: DATA_W]};
        end

        xbar_rr_arb #(.N(NUM_CORES)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (hit[b]),
            .en      (room),
            .gnt     (gnt[b]),
            .gnt_idx (widx)
        );

        xbar_req_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .push_data (push_ent),
            .pop       (bank_ready[b]),
            .valid     (bank_valid[b]),
            .head      (head),
            .full      (full)
        );

        assign bank_src [b*SRC_W  +: SRC_W ] = head[ENT_W-1 -: SRC_W];
        assign bank_addr[b*ADDR_W +: ADDR_W] = head[DATA_W +: ADDR_W];
        assign bank_data[b*DATA_W +: DATA_W] = head[DATA_W-1:0];
    end
endmodule

// File: rtl/core_bank_xbar_chk.sv
// Module: port-level checker for core_bank_xbar.
// It keeps a shadow occupancy count per bank from the accepted and popped
// handshakes and checks the queue limit, the valid flag and the port hold.
// Assumes: it is attached to every instance through the bind below.
module core_bank_xbar_chk #(
    parameter int NUM_CORES  = 8,
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int QDEPTH     = 4
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic [NUM_CORES-1:0]                   req_valid,
    input logic [NUM_CORES*ADDR_W-1:0]            req_addr,
    input logic [NUM_CORES*DATA_W-1:0]            req_data,
    input logic [NUM_CORES-1:0]                   req_ready,
    input logic [NUM_BANKS-1:0]                   bank_valid,
    input logic [NUM_BANKS*ADDR_W-1:0]            bank_addr,
    input logic [NUM_BANKS*DATA_W-1:0]            bank_data,
    input logic [NUM_BANKS*$clog2(NUM_CORES)-1:0] bank_src,
    input logic [NUM_BANKS-1:0]                   bank_ready
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int BSEL_W = $clog2(NUM_BANKS);
    localparam int SRC_W  = $clog2(NUM_CORES);
    localparam int CW     = $clog2(QDEPTH + 2);

    // R1: one cycle after reset is seen, every bank port is empty.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (bank_valid == '0));

    // R4: a core is never accepted without a request.
    assert_ready_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_CORES-1:0] acc;
        logic [CW-1:0]        occ;
        logic                 pop;

        // Collect the cores accepted into this bank this cycle.
        always_comb begin
            for (int c = 0; c < NUM_CORES; c++)
                acc[c] = req_valid[c] && req_ready[c] &&
                         (req_addr[c*ADDR_W + OFS_W +: BSEL_W] == BSEL_W'(b));
            pop = bank_valid[b] && bank_ready[b];
        end

        // Shadow occupancy of this bank's queue, counted from the handshakes.
        always_ff @(posedge clk) begin
            if (!rst_n) occ <= '0;
            else        occ <= occ + CW'(|acc) - CW'(pop);
        end

        // R8: at most one request enters a bank per cycle.
        assert_one_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(acc) <= 1);

        // R4: the shadow occupancy never exceeds the queue depth.
        assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            occ <= CW'(QDEPTH));

        // R4: a full queue accepts nothing, even while popping.
        assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (occ == CW'(QDEPTH)) |-> (acc == '0));

        // R6: the port shows valid exactly while entries are queued.
        assert_valid_tracks_occ_R6: assert property (@(posedge clk) disable iff (!rst_n)
            bank_valid[b] == (occ != '0));

        // R9: a stalled head stays put.
        assert_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_valid[b] && !bank_ready[b]) |=>
                (bank_valid[b] &&
                 $stable(bank_addr[b*ADDR_W +: ADDR_W]) &&
                 $stable(bank_data[b*DATA_W +: DATA_W]) &&
                 $stable(bank_src[b*SRC_W +: SRC_W])));
    end
endmodule

bind core_bank_xbar core_bank_xbar_chk #(
    .NUM_CORES  (NUM_CORES),
    .NUM_BANKS  (NUM_BANKS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINE_BYTES (LINE_BYTES),
    .QDEPTH     (QDEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_ready  (req_ready),
    .bank_valid (bank_valid),
    .bank_addr  (bank_addr),
    .bank_data  (bank_data),
    .bank_src   (bank_src),
    .bank_ready (bank_ready)
);

// File: tb/core_bank_xbar_bench.sv
// Directed bench for core_bank_xbar: one task per scenario, each checking itself.
module core_bank_xbar_bench;
    localparam int NC = 8;
    localparam int NB = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     req_valid = '0;
    logic [NC*AW-1:0]  req_addr = '0;
    logic [NC*DW-1:0]  req_data = '0;
    logic [NC-1:0]     req_ready;
    logic [NB-1:0]     bank_valid;
    logic [NB*AW-1:0]  bank_addr;
    logic [NB*DW-1:0]  bank_data;
    logic [NB*SW-1:0]  bank_src;
    logic [NB-1:0]     bank_ready = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    core_bank_xbar u_core_bank_xbar (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(req_ready), .bank_valid(bank_valid),
        .bank_addr(bank_addr), .bank_data(bank_data), .bank_src(bank_src),
        .bank_ready(bank_ready)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Address of core c's request to bank b, with noise outside bits [7:6].
    function automatic logic [AW-1:0] addr_of(input int c, input int b, input int n);
        return 32'h5A00_0000 | (AW'(n) << 12) | (AW'(c) << 8) | (AW'(b) << 6) | 32'h2B;
    endfunction

    task automatic drive(input int c, input int b, input int n);
        req_valid[c] = 1'b1;
        req_addr[c*AW +: AW] = addr_of(c, b, n);
        req_data[c*DW +: DW] = 32'hD000_0000 | (n << 4) | c;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = '0; bank_ready = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pop the head of bank b and compare it with the expected entry.
    task automatic expect_head(input string req, input int b, input int c, input int n);
        @(negedge clk);
        #1;
        check(req, "bank valid", 64'(bank_valid[b]), 64'd1);
        check(req, "bank src", 64'(bank_src[b*SW +: SW]), 64'(c));
        check(req, "bank addr", 64'(bank_addr[b*AW +: AW]), 64'(addr_of(c, b, n)));
        check(req, "bank data", 64'(bank_data[b*DW +: DW]), 64'(32'hD000_0000 | (n << 4) | c));
        bank_ready[b] = 1'b1;
        @(posedge clk);
        #1 bank_ready[b] = 1'b0;
    endtask

    // R1: reset leaves every bank port empty and nothing ready.
    task automatic t_reset();
        do_reset();
        #1;
        check("R1", "bank_valid after reset", 64'(bank_valid), 64'd0);
        check("R1", "req_ready idle", 64'(req_ready), 64'd0);
    endtask

    // R2 R3: each core lands in the bank named by addr[7:6], tagged with its number.
    task automatic t_bank_select();
        do_reset();
        for (int b = 0; b < NB; b++) begin
            @(negedge clk);
            drive(2*b + 1, b, b);
            #1 check("R2", "ready to empty bank", 64'(req_ready), 64'(1 << (2*b + 1)));
            @(posedge clk);
            #1 req_valid = '0;
            @(negedge clk);
            #1 check("R2", "only target bank valid", 64'(bank_valid), 64'(1 << b));
            expect_head("R3", b, 2*b + 1, b);
        end
    endtask

    // R7: four cores to four banks are all taken in one cycle.
    task automatic t_parallel();
        do_reset();
        @(negedge clk);
        for (int c = 0; c < 4; c++) drive(c, 3 - c, 7);
        #1 check("R7", "four grants at once", 64'(req_ready), 64'h0F);
        @(posedge clk);
        #1 req_valid = '0;
        @(negedge clk);
        #1 check("R7", "four banks filled", 64'(bank_valid), 64'hF);
        for (int c = 0; c < 4; c++) expect_head("R7", 3 - c, c, 7);
    endtask

    // R5 R4 R6: round-robin into bank 1, fill to depth, block, wrap.
    task automatic t_round_robin();
        do_reset();
        @(negedge clk);
        for (int c = 0; c < NC; c++) drive(c, 1, 1);
        for (int k = 0; k < 4; k++) begin
            #1 check("R5", "grant order", 64'(req_ready), 64'(1 << k));
            @(negedge clk);
            req_valid[k] = 1'b0;
        end
        #1 check("R4", "full queue blocks", 64'(req_ready), 64'd0);
        @(negedge clk);
        #1 check("R4", "still blocked and held", 64'(req_ready), 64'd0);
        bank_ready[1] = 1'b1;
        #1 check("R4", "no grant during pop of full", 64'(req_ready), 64'd0);
        check("R6", "oldest head", 64'(bank_src[1*SW +: SW]), 64'd0);
        @(negedge clk);
        bank_ready[1] = 1'b0;
        #1 check("R5", "next core after pointer", 64'(req_ready), 64'h10);
        @(negedge clk);
        req_valid = '0;
        for (int c = 1; c <= 4; c++) expect_head("R6", 1, c, 1);
        // Pointer now at core 5: core 6 must win over core 1, then core 1.
        @(negedge clk);
        drive(1, 1, 2);
        drive(6, 1, 2);
        #1 check("R5", "wrap favours core 6", 64'(req_ready), 64'h40);
        @(negedge clk);
        req_valid[6] = 1'b0;
        #1 check("R5", "then core 1", 64'(req_ready), 64'h02);
        @(negedge clk);
        req_valid = '0;
        expect_head("R5", 1, 6, 2);
        expect_head("R5", 1, 1, 2);
    endtask

    // R6 R9: one core streams to bank 2; the stalled head holds, then order is kept.
    task automatic t_order_hold();
        do_reset();
        for (int n = 1; n <= 3; n++) begin
            @(negedge clk);
            drive(5, 2, n);
            #1 check("R6", "stream accepted", 64'(req_ready), 64'h20);
            @(posedge clk);
            #1 req_valid = '0;
        end
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            #1 check("R9", "held data", 64'(bank_data[2*DW +: DW]), 64'(32'hD000_0015));
            check("R9", "held valid", 64'(bank_valid[2]), 64'd1);
        end
        for (int n = 1; n <= 3; n++) expect_head("R6", 2, 5, n);
        @(negedge clk);
        #1 check("R6", "bank drained", 64'(bank_valid), 64'd0);
    endtask

    initial begin
        t_reset();
        t_bank_select();
        t_parallel();
        t_round_robin();
        t_order_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule